// File: doc/BRIEF.md
# Lockable Watchdog Supervisor with Reset-Cause Flag

This block watches a processor for signs of life. Each `kick` pulse (in the system, the start condition seen on the serial bus) restarts a timer that advances on a one-millisecond `tick` strobe. If the timer reaches the period picked by a 3-bit code before the next kick arrives, the block raises `wdt_rst` for a fixed number of ticks. The timer then starts again from zero.

An 8-bit control byte sets the period and holds a write-lock enable, a volatile reset-cause flag and three block-lock bits. Writes arrive already authorized as `wr_auth` with `wr_data`. They are refused while both the external `wp_pin` and the stored lock enable are high. `pwr_fail` clears the flag, so software can tell a power loss from a watchdog expiry. All pins are plain control and status levels or strobes. There is no streamed data, so no valid/ready handshake is needed.

Top module: `wdt_supervisor`

## Requirements
- R1: After `rst_n` is released, `ctrl_q` equals the parameter `CTRL_INIT` (default 8'h00) and `wdt_rst` is low.
- R2: Bit positions of `ctrl_q`: bit 7 is the write-lock enable, bit 6 is the flag, bits 5:3 are the period code, bits 2:0 are block-lock bits that are stored and read back only.
- R3: A cycle with `wr_auth` high loads `wr_data` into `ctrl_q` at the next clock edge when `wp_pin` is low or bit 7 is low. With `wr_auth` low the register holds.
- R4: When `wp_pin` and bit 7 are both high, an authorized write leaves `ctrl_q` unchanged.
- R5: `pwr_fail` high in a cycle makes bit 6 zero after the next edge. This wins over a write in the same cycle, and the write's other bits still load.
- R6: A watchdog expiry and its reset pulse leave every bit of `ctrl_q`, including the flag, unchanged.
- R7: Period code to ticks: 000 gives 1000, 001 gives 450, 010 gives 150, 100 gives 60000, 101 gives 20000, 110 gives 10000, 111 gives 5000. `wdt_rst` rises at the edge that samples the period-th tick after the last kick.
- R8: A kick zeroes the count. A kick in the same cycle as the terminal tick prevents the reset.
- R9: Only cycles with `tick` high advance the count or the pulse.
- R10: `wdt_rst` stays high for `RST_TICKS` ticks (default 4), and kicks during the pulse are ignored. Counting restarts from zero when the pulse ends.
- R11: The count is zeroed at the edge after the period code in `ctrl_q` changes.
- R12: Code 011 holds the count at zero and never raises `wdt_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe per millisecond |
| kick | input | 1 | Restart pulse from the bus start detector |
| pwr_fail | input | 1 | Low-voltage detect; clears the flag |
| wp_pin | input | 1 | External write-protect level |
| wr_auth | input | 1 | Authorized control-byte write strobe |
| wr_data | input | 8 | Control byte to write |
| ctrl_q | output | 8 | Current control byte |
| wdt_rst | output | 1 | Watchdog reset output, active high |

## Verification
Two pairs of events can land in the same cycle. The first pair is a kick and the terminal tick: the bench drives both on the cycle that would otherwise expire the timer. It then expects `wdt_rst` to stay low and to rise only a full period of ticks later. The second pair is `pwr_fail` and a write that sets the flag. The bench asserts both in one cycle and expects the written byte with bit 6 forced to zero.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned CNT_W = 16;

  typedef logic [2:0] wd_code_t;

  localparam wd_code_t CODE_OFF = 3'b011;

  localparam int unsigned LIM_C0 = 1000;
  localparam int unsigned LIM_C1 = 450;
  localparam int unsigned LIM_C2 = 150;
  localparam int unsigned LIM_C4 = 60000;
  localparam int unsigned LIM_C5 = 20000;
  localparam int unsigned LIM_C6 = 10000;
  localparam int unsigned LIM_C7 = 5000;

  typedef struct packed {
    logic     lock_en;
    logic     flag;
    wd_code_t period;
    logic [2:0] blk;
  } ctrl_t;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
#(
  parameter logic [7:0] INIT = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp_pin,
  input  logic       wr_auth,
  input  logic [7:0] wr_data,
  input  logic       pwr_fail,
  output ctrl_t      ctrl
);
  logic wr_open;
  assign wr_open = wr_auth && !(wp_pin && ctrl.lock_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= ctrl_t'(INIT);
    end else begin
      if (wr_open) ctrl <= ctrl_t'(wr_data);
      if (pwr_fail) ctrl.flag <= 1'b0;
    end
  end

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_auth && wp_pin && ctrl.lock_en && !pwr_fail) |=> $stable(ctrl));

  // R5
  pf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> !ctrl.flag);
endmodule

// File: rtl/wdt_period_dec.sv
module wdt_period_dec
  import wdt_pkg::*;
(
  input  wd_code_t         code,
  output logic [CNT_W-1:0] limit,
  output logic             off
);
  always_comb begin
    off = 1'b0;
    unique case (code)
      3'b000: limit = CNT_W'(LIM_C0);
      3'b001: limit = CNT_W'(LIM_C1);
      3'b010: limit = CNT_W'(LIM_C2);
      3'b100: limit = CNT_W'(LIM_C4);
      3'b101: limit = CNT_W'(LIM_C5);
      3'b110: limit = CNT_W'(LIM_C6);
      3'b111: limit = CNT_W'(LIM_C7);
      default: begin
        limit = '1;
        off   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned RST_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             kick,
  input  wd_code_t         code,
  input  logic [CNT_W-1:0] limit,
  input  logic             off,
  output logic             wdt_rst
);
  localparam int unsigned PW = $clog2(RST_TICKS + 1);

  logic [CNT_W-1:0] cnt;
  logic [PW-1:0]    pcnt;
  logic             rst_q;
  wd_code_t         code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      pcnt   <= '0;
      rst_q  <= 1'b0;
      code_q <= '0;
    end else begin
      code_q <= code;
      if (rst_q) begin
        cnt <= '0;
        if (tick) begin
          if (pcnt == PW'(RST_TICKS - 1)) begin
            rst_q <= 1'b0;
            pcnt  <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
      end else if ((code != code_q) || off || kick) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == limit - 1'b1) begin
          rst_q <= 1'b1;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign wdt_rst = rst_q;

  // R8
  kick_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !rst_q) |=> !rst_q);

  // R12
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off && !rst_q) |=> !rst_q);

  // R9
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> $past(tick));

  // R10
  fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_q) |-> $past(tick));

  // R7
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!off && code == code_q) |-> cnt < limit);
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
  import wdt_pkg::*;
#(
  parameter logic [7:0]  CTRL_INIT = 8'h00,
  parameter int unsigned RST_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       kick,
  input  logic       pwr_fail,
  input  logic       wp_pin,
  input  logic       wr_auth,
  input  logic [7:0] wr_data,
  output logic [7:0] ctrl_q,
  output logic       wdt_rst
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] limit;
  logic             off;

  wdt_ctrl_reg #(.INIT(CTRL_INIT)) u_reg (
    .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .wr_auth(wr_auth),
    .wr_data(wr_data), .pwr_fail(pwr_fail), .ctrl(ctrl)
  );

  wdt_period_dec u_dec (
    .code(ctrl.period), .limit(limit), .off(off)
  );

  wdt_timer #(.RST_TICKS(RST_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick),
    .code(ctrl.period), .limit(limit), .off(off), .wdt_rst(wdt_rst)
  );

  assign ctrl_q = ctrl;
endmodule

// File: tb/test_wdt_supervisor.sv
module test_wdt_supervisor;
  localparam int RST = 4;

  logic clk = 1'b0;
  logic rst_n, tick, kick, pwr_fail, wp_pin, wr_auth;
  logic [7:0] wr_data;
  logic [7:0] ctrl_q;
  logic wdt_rst;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  wdt_supervisor #(.CTRL_INIT(8'h00), .RST_TICKS(RST)) i_wdt_supervisor (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick), .pwr_fail(pwr_fail),
    .wp_pin(wp_pin), .wr_auth(wr_auth), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .wdt_rst(wdt_rst)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d, logic auth);
    wr_data = d;
    wr_auth = auth;
    step();
    wr_auth = 1'b0;
    step();
  endtask

  task automatic kick_once();
    kick = 1'b1;
    step();
    kick = 1'b0;
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      step();
      tick = 1'b0;
      for (int j = 1; j < gap; j++) step();
    end
  endtask

  function automatic int lim(int c);
    case (c)
      0: return 1000;
      1: return 450;
      2: return 150;
      4: return 60 * 1000;
      5: return 20 * 1000;
      6: return 10 * 1000;
      default: return 5 * 1000;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; kick = 1'b0; pwr_fail = 1'b0;
    wp_pin = 1'b0; wr_auth = 1'b0; wr_data = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 ctrl", ctrl_q, 8'h00);
    chk("R1 rst", wdt_rst, 1'b0);

    // R3 R4: sweep lock enable, pin and authorization
    for (int e = 0; e < 2; e++)
      for (int p = 0; p < 2; p++)
        for (int a = 0; a < 2; a++) begin
          logic [7:0] base, nw, exp;
          base = {e[0], 1'b0, 3'b011, 3'b000};
          nw   = {e[0], 1'b1, 3'b011, 3'b101};
          wp_pin = 1'b0;
          wr(base, 1'b1);
          wp_pin = p[0];
          wr(nw, a[0]);
          exp = (a[0] && !(p[0] && e[0])) ? nw : base;
          chk((p[0] && e[0]) ? "R4 locked write" : "R3 write gate", ctrl_q, exp);
        end
    wp_pin = 1'b0;

    // R5: power fail clears flag; same cycle as write
    wr({1'b0, 1'b1, 3'b011, 3'b001}, 1'b1);
    pwr_fail = 1'b1; step(); pwr_fail = 1'b0;
    chk("R5 pf clear", ctrl_q, {1'b0, 1'b0, 3'b011, 3'b001});
    wr_data = {1'b0, 1'b1, 3'b011, 3'b110};
    wr_auth = 1'b1; pwr_fail = 1'b1; step();
    wr_auth = 1'b0; pwr_fail = 1'b0;
    chk("R5 pf beats write", ctrl_q, {1'b0, 1'b0, 3'b011, 3'b110});
    chk("R2 field layout", {29'b0, ctrl_q[5:3]}, 3'b011);

    // R7 R6: every enabled period, tick every cycle
    for (int c = 0; c < 8; c++) begin
      logic [7:0] v;
      if (c == 3) continue;
      v = {1'b0, 1'b1, c[2:0], 3'b010};
      wr(v, 1'b1);
      kick_once();
      ticks(lim(c) - 1, 1);
      chk("R7 before expiry", wdt_rst, 1'b0);
      ticks(1, 1);
      chk("R7 at expiry", wdt_rst, 1'b1);
      chk("R6 ctrl kept", ctrl_q, v);
      ticks(RST, 1);
      chk("R10 pulse end", wdt_rst, 1'b0);
    end

    // R10: kicks ignored during pulse, restart from zero
    wr({1'b0, 1'b1, 3'b010, 3'b000}, 1'b1);
    kick_once();
    ticks(150, 1);
    chk("R10 rise", wdt_rst, 1'b1);
    kick = 1'b1; tick = 1'b1; step(); kick = 1'b0; tick = 1'b0;
    ticks(RST - 2, 1);
    chk("R10 kick ignored", wdt_rst, 1'b1);
    ticks(1, 1);
    chk("R10 length", wdt_rst, 1'b0);
    ticks(149, 1);
    chk("R10 restart early", wdt_rst, 1'b0);
    ticks(1, 1);
    chk("R10 restart full", wdt_rst, 1'b1);
    ticks(RST, 1);

    // R8: kick coincides with terminal tick
    kick_once();
    ticks(149, 1);
    kick = 1'b1; tick = 1'b1; step(); kick = 1'b0; tick = 1'b0;
    chk("R8 kick wins", wdt_rst, 1'b0);
    ticks(149, 1);
    chk("R8 full period", wdt_rst, 1'b0);
    ticks(1, 1);
    chk("R8 expiry", wdt_rst, 1'b1);
    ticks(RST, 1);

    // R9: sparse ticks
    kick_once();
    ticks(149, 3);
    chk("R9 sparse before", wdt_rst, 1'b0);
    ticks(1, 3);
    chk("R9 sparse expiry", wdt_rst, 1'b1);
    ticks(RST, 3);
    chk("R9 sparse end", wdt_rst, 1'b0);

    // R11: period code change clears count
    wr({1'b0, 1'b0, 3'b000, 3'b000}, 1'b1);
    kick_once();
    ticks(900, 1);
    wr({1'b0, 1'b0, 3'b010, 3'b000}, 1'b1);
    ticks(149, 1);
    chk("R11 before", wdt_rst, 1'b0);
    ticks(1, 1);
    chk("R11 restart", wdt_rst, 1'b1);
    ticks(RST, 1);

    // R12: disabled code never resets
    begin
      int seen;
      seen = 0;
      wr({1'b0, 1'b0, 3'b011, 3'b000}, 1'b1);
      for (int i = 0; i < 2000; i++) begin
        ticks(1, 1);
        if (wdt_rst) seen++;
      end
      chk("R12 disabled", seen, 0);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule